// File: doc/BRIEF.md
# Full-Bridge Power-Up Interlock Sequencer

This block takes a full-bridge gate driver out of power-up without letting current shoot through either leg. It watches a supply-good flag, an active-low enable request and the comparator direction bit that steers the bridge. From these it drives two outputs: a driver disable line, and a low-side hold line that keeps both low switches off.

The sequence starts when the supply is good and enable is requested. It does not matter which of the two arrives first. At that point the disable line drops, but the low-side hold stays asserted. The hold remains until two things have happened:

- a programmable window of clock cycles has elapsed;
- the direction bit has made one full excursion, meaning one rising and one falling transition in either order. This excursion puts the high-side state into a known condition.

Only then does the hold drop and the ready output rise. If the window runs out before the excursion completes, a waiting status is raised. Losing the supply, or withdrawing the enable, at any time sends the block back to the disabled state and discards all progress.

Top module: `bridge_startup_seq`

## Requirements
- R1: After reset the outputs are drvDisable=1, lowHold=1, ready=0 and waitCycle=0.
- R2: At each clock edge where supplyGood=0 or enableReqN=1, the block enters the disabled state. Its outputs there are drvDisable=1, lowHold=1, ready=0 and waitCycle=0.
- R3: From the disabled state, the first edge that samples supplyGood=1 together with enableReqN=0 enters the hold state, with drvDisable=0 and lowHold=1. This holds when the enable request arrives after the supply is already good.
- R4: The hold state lasts at least WINDOW+1 cycles. Its cycle counter starts at zero on entry, advances by one per cycle in hold, and saturates at WINDOW.
- R5: A direction transition counts only when it is sampled at an edge while the block is already in the hold state. Release needs at least one rising and at least one falling transition, in either order. A transition sampled in the disabled state has no effect.
- R6: In the hold state, once the counter has reached WINDOW without a complete excursion, waitCycle=1 and lowHold stays 1. Both stay until the excursion completes.
- R7: The hold state is left for the run state at the first edge at which the counter already equals WINDOW and both transitions are already recorded. In the run state lowHold=0.
- R8: A return to the disabled state clears the counter and the recorded transitions. A new attempt therefore needs a fresh window and a fresh excursion.
- R9: ready=1 exactly in the run state, where drvDisable=0 and lowHold=0. ready and lowHold are never equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyGood | input | 1 | Supply has reached operating level |
| enableReqN | input | 1 | Active-low enable request |
| dirIn | input | 1 | Comparator direction bit steering the bridge |
| drvDisable | output | 1 | Forces all bridge gates off when high |
| lowHold | output | 1 | Keeps both low-side switches off when high |
| waitCycle | output | 1 | Window elapsed, still waiting for a direction excursion |
| ready | output | 1 | Hold released, normal operation running |

## Verification
Several properties are checked on every cycle:
- the forced return to the disabled state when supply or enable is lost;
- the rule that the run state is entered only from hold, with both the window and the excursion complete;
- the saturation of the cycle counter;
- the clearing of progress whenever the block is disabled.

The scenarios cover the behaviour that depends on exact cycle counts. One scenario measures the exact length of the hold. Others cover the waiting status after an expired window and the two orders of the excursion. One shows that a transition made while disabled is not counted, and one shows that an aborted attempt must start over. A seeded random phase compares every output against a bench model for thousands of cycles.

// File: rtl/bridge_startup_pkg.sv
package bridge_startup_pkg;

  typedef enum logic [1:0] {
    SEQ_OFF  = 2'd0,
    SEQ_HOLD = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic runTimer;
    logic trackEdges;
  } seq_strobe_t;

endpackage

// File: rtl/bridge_startup_dp.sv
module bridge_startup_dp
  import bridge_startup_pkg::*;
#(
  parameter int unsigned WINDOW = 1_000_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  seq_strobe_t strobe,
  input  logic        dirIn,
  output logic        windowDone,
  output logic        cycleDone
);

  localparam int unsigned CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] WIN_L = CW'(WINDOW);

  logic [CW-1:0] winCnt;
  logic          dirPrev;
  logic          sawRise;
  logic          sawFall;

  // window counter, saturating at WINDOW
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (strobe.clearAll) begin
      winCnt <= '0;
    end else if (strobe.runTimer && (winCnt != WIN_L)) begin
      winCnt <= winCnt + 1'b1;
    end
  end

  // direction excursion record
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirPrev <= 1'b0;
      sawRise <= 1'b0;
      sawFall <= 1'b0;
    end else begin
      dirPrev <= dirIn;
      if (strobe.clearAll) begin
        sawRise <= 1'b0;
        sawFall <= 1'b0;
      end else if (strobe.trackEdges) begin
        if (dirIn && !dirPrev) sawRise <= 1'b1;
        if (!dirIn && dirPrev) sawFall <= 1'b1;
      end
    end
  end

  assign windowDone = (winCnt == WIN_L);
  assign cycleDone  = sawRise && sawFall;

  a_r4_timer_bound: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= WIN_L);

  a_r8_clear_progress: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (winCnt == '0) && !sawRise && !sawFall);

  a_r5_record_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clearAll && cycleDone) |=> cycleDone);

endmodule

// File: rtl/bridge_startup_ctrl.sv
module bridge_startup_ctrl
  import bridge_startup_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        supplyGood,
  input  logic        enableReqN,
  input  logic        windowDone,
  input  logic        cycleDone,
  output seq_strobe_t strobe,
  output logic        drvDisable,
  output logic        lowHold,
  output logic        waitCycle,
  output logic        ready
);

  seq_state_t state;
  seq_state_t stateNext;
  logic       goAllowed;

  assign goAllowed = supplyGood && !enableReqN;

  always_comb begin
    stateNext = state;
    if (!goAllowed) begin
      stateNext = SEQ_OFF;
    end else begin
      unique case (state)
        SEQ_OFF:  stateNext = SEQ_HOLD;
        SEQ_HOLD: if (windowDone && cycleDone) stateNext = SEQ_RUN;
        SEQ_RUN:  stateNext = SEQ_RUN;
        default:  stateNext = SEQ_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_OFF;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.clearAll   = (state == SEQ_OFF);
    strobe.runTimer   = (state == SEQ_HOLD);
    strobe.trackEdges = (state == SEQ_HOLD);
  end

  assign drvDisable = (state == SEQ_OFF);
  assign lowHold    = (state != SEQ_RUN);
  assign ready      = (state == SEQ_RUN);
  assign waitCycle  = (state == SEQ_HOLD) && windowDone && !cycleDone;

  a_r2_drop_to_off: assert property (@(posedge clk) disable iff (!rstN)
    (!supplyGood || enableReqN) |=> (state == SEQ_OFF));

  a_r7_release_gate: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_HOLD && stateNext == SEQ_RUN) |-> (windowDone && cycleDone));

  a_r3_run_from_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_OFF) |=> (state != SEQ_RUN));

endmodule

// File: rtl/bridge_startup_seq.sv
module bridge_startup_seq
  import bridge_startup_pkg::*;
#(
  parameter int unsigned WINDOW = 1_000_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyGood,
  input  logic enableReqN,
  input  logic dirIn,
  output logic drvDisable,
  output logic lowHold,
  output logic waitCycle,
  output logic ready
);

  seq_strobe_t strobe;
  logic        windowDone;
  logic        cycleDone;

  bridge_startup_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .supplyGood (supplyGood),
    .enableReqN (enableReqN),
    .windowDone (windowDone),
    .cycleDone  (cycleDone),
    .strobe     (strobe),
    .drvDisable (drvDisable),
    .lowHold    (lowHold),
    .waitCycle  (waitCycle),
    .ready      (ready)
  );

  bridge_startup_dp #(.WINDOW(WINDOW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .dirIn      (dirIn),
    .windowDone (windowDone),
    .cycleDone  (cycleDone)
  );

endmodule

// File: tb/test_bridge_startup_seq.sv
module test_bridge_startup_seq;

  localparam int unsigned WIN = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyGood = 1'b0;
  logic enableReqN = 1'b1;
  logic dirIn = 1'b0;
  logic drvDisable, lowHold, waitCycle, ready;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  bit modelOn = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bridge_startup_seq #(.WINDOW(WIN)) i_bridge_startup_seq (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .enableReqN(enableReqN),
    .dirIn(dirIn), .drvDisable(drvDisable), .lowHold(lowHold),
    .waitCycle(waitCycle), .ready(ready)
  );

  // reference model built from the requirements: 0 off, 1 hold, 2 run
  int mState = 0;
  int mCnt = 0;
  bit mRise = 0, mFall = 0, mPrev = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mRise = 0; mFall = 0; mPrev = 0;
    end else begin
      int nxt;
      nxt = mState;
      if (!supplyGood || enableReqN) nxt = 0;
      else if (mState == 0) nxt = 1;
      else if (mState == 1 && mCnt == WIN && mRise && mFall) nxt = 2;
      if (mState == 0) begin
        mCnt = 0; mRise = 0; mFall = 0;
      end else if (mState == 1) begin
        if (mCnt < WIN) mCnt++;
        if (dirIn && !mPrev) mRise = 1;
        if (!dirIn && mPrev) mFall = 1;
      end
      mPrev = dirIn;
      mState = nxt;
    end
  end

  function automatic bit expDis();   return mState == 0; endfunction
  function automatic bit expHold();  return mState != 2; endfunction
  function automatic bit expReady(); return mState == 2; endfunction
  function automatic bit expWait();
    return (mState == 1) && (mCnt == WIN) && !(mRise && mFall);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (modelOn) begin
      check("R2 drvDisable", drvDisable, expDis());
      check("R7 lowHold", lowHold, expHold());
      check("R9 ready", ready, expReady());
      check("R6 waitCycle", waitCycle, expWait());
    end
  end

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int n;
    int r;
    r = $urandom(32'h5EED);
    @(negedge clk);
    // R1 reset values
    check("R1 drvDisable", drvDisable, 1'b1);
    check("R1 lowHold", lowHold, 1'b1);
    check("R1 ready", ready, 1'b0);
    check("R1 waitCycle", waitCycle, 1'b0);
    rstN = 1'b1;
    modelOn = 1'b1;

    // R2 supply good alone does not enable
    supplyGood = 1'b1;
    repeat (5) step();
    check("R2 stays disabled", drvDisable, 1'b1);
    // R3 enable arriving later starts the hold
    enableReqN = 1'b0;
    step();
    check("R3 disable released", drvDisable, 1'b0);
    check("R3 hold asserted", lowHold, 1'b1);

    // R4/R7 exact hold length with early excursion
    n = 0;
    while (lowHold && n < 1000) begin
      n++;
      if (n == 1) dirIn = 1'b1;
      if (n == 2) dirIn = 1'b0;
      step();
    end
    check("R4 hold length", n == WIN + 1, 1'b1);
    if (n != WIN + 1) $display("FAIL R4: actual %0d expected %0d", n, WIN + 1);
    check("R9 ready in run", ready, 1'b1);

    // R8 abort by withdrawing enable
    enableReqN = 1'b1;
    step();
    check("R8 abort disables", drvDisable, 1'b1);
    check("R8 abort holds low", lowHold, 1'b1);
    // R5 transition while disabled is ignored
    dirIn = 1'b1;
    step();
    step();
    enableReqN = 1'b0;
    step();
    check("R3 re-entry hold", lowHold, 1'b1);
    repeat (WIN + 5) step();
    // R6 waiting because no excursion in this attempt (R8 record cleared)
    check("R6 waiting flagged", waitCycle, 1'b1);
    check("R6 hold kept", lowHold, 1'b1);
    // R5 fall first, then rise
    dirIn = 1'b0;
    step();
    check("R5 half excursion keeps hold", lowHold, 1'b1);
    check("R5 half excursion still waiting", waitCycle, 1'b1);
    dirIn = 1'b1;
    step();
    check("R7 release one cycle later", lowHold, 1'b1);
    step();
    check("R7 hold released", lowHold, 1'b0);
    check("R9 ready raised", ready, 1'b1);
    check("R9 disable low", drvDisable, 1'b0);

    // R2 supply loss from run
    supplyGood = 1'b0;
    step();
    check("R2 supply loss", drvDisable, 1'b1);
    check("R2 ready cleared", ready, 1'b0);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      supplyGood = ($urandom % 100) < 97;
      enableReqN = ($urandom % 100) < 3;
      if (($urandom % 10) == 0) dirIn = ~dirIn;
      step();
    end
    finishRun();
  end

endmodule